// File: doc/BRIEF.md
# TDM Serial Input Channel Demultiplexer

This block takes a serial time-division-multiplexed bit stream with a frame sync and splits it into up to sixteen logical channels. Each channel has its own bit-slot offset within the frame and a sample length of 1, 2, 4 or 8 bits. An enabled channel shifts its bits into a 16-bit shift register. The newest bit enters at the MSB and moves toward the LSB. When a full 16-bit word has built up, possibly over several frames, the word is copied into the channel's parallel data register. A buffer-full interrupt pulses at a programmed frame rate.

In an alternate mode, all sixteen shift registers are copied to the data registers together at each rate tick. A sync that arrives before the programmed frame length has been sampled raises a frame-error pulse. A combinational configuration-error flag reports a valid vector with gaps, and channels that overlap or are out of order. Software reaches the block through a simple single-cycle register port. Attributes may only be changed while the section is held in reset.

Top module: `tdm_demux`

## Requirements
- R1: The control register sits at address 48. Its bit 4 is the section reset and its bit 2 is the enable. A write with bit 4 set stops the section and clears all counters, shift progress and data registers. A later write with bit 2 set (bit 4 clear) starts it. While the section is stopped, serial input leaves the data registers unchanged.
- R2: The valid vector sits at address 49, and bit n enables channel n. A disabled channel never loads its data register in normal mode, so it reads as zero.
- R3: Channel n has its start slot at address 16+n, bits [7:0]. Its length code sits at address 32+n, bits [1:0], where 00=1, 01=2, 10=4 and 11=8 bits. The channel samples the slots from start to start+length-1. Slot 0 is the bit sampled together with the sync.
- R4: Each sampled bit enters the MSB of the shift register and shifts toward the LSB. In normal mode, the data register at address n is loaded only when 16 bits have accumulated. The first-arrived bit of the word then sits at bit 0.
- R5: `buf_irq` is a one-cycle pulse raised after every 2^(rate+1) completed frames. The rate is control bits [1:0].
- R6: Control bit 9 selects the transfer-all mode. At every rate tick, all 16 shift registers are copied at once, including the bit sampled in that cycle, so the data need not be right-justified. The mode bit can be changed while the section runs, without a reset.
- R7: While the section is enabled, writes to the valid vector, start slots, length codes and frame length are ignored, and reading them back returns the old values.
- R8: The frame length register sits at address 50 and holds the slots per frame minus one in bits [7:0]. A sync that arrives inside a frame before all of its slots have been sampled gives a one-cycle `ferr_irq`. Complete frames give none.
- R9: `cfg_err` is high when the set bits of the valid vector do not form a contiguous run starting at bit 0.
- R10: `cfg_err` is high when an enabled channel n>0 has a start slot below the start slot of channel n-1 plus that channel's sample length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock rising-edge strobe; serial inputs are sampled when high |
| ser_din | input | 1 | Serial data |
| fsync | input | 1 | Frame sync, marks slot 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| buf_irq | output | 1 | Buffer-full interrupt pulse |
| ferr_irq | output | 1 | Frame-error interrupt pulse |
| cfg_err | output | 1 | Configuration error flag |

## Verification
The main test drives four packed channels of lengths 8, 4, 2 and 1 with a position-dependent bit pattern. Because each length completes its word after a different number of frames, a wrong slot window, a wrong bit order or a wrong copy time each give a distinct mismatch. A sweep over every length code against three start offsets and four interrupt rates separates the offset arithmetic from the length decode and the rate divider. The transfer-all run checks the left-aligned partial words. Switching back to normal mode without a reset shows that the shift progress continues. A truncated frame and contrived bad valid vectors and overlaps, including the exact-boundary case, cover the error paths.

// File: rtl/tdm_demux_pkg.sv
// Shared constants for the TDM input demultiplexer: register addresses,
// control-bit positions and the sample-length decode.
package tdm_demux_pkg;

    localparam int ADDR_START_BASE = 16;
    localparam int ADDR_LEN_BASE   = 32;
    localparam int ADDR_CTRL       = 48;
    localparam int ADDR_VALID      = 49;
    localparam int ADDR_FLEN       = 50;

    localparam int CTRL_EN_BIT  = 2;
    localparam int CTRL_RST_BIT = 4;
    localparam int CTRL_ALT_BIT = 9;

    // Length code to bit count: 0->1, 1->2, 2->4, 3->8.
    function automatic logic [3:0] code_len(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/tdm_demux_regs.sv
// Register file and control sequencing for the demultiplexer.
// Holds the control bits, the valid vector, the per-channel start slots and
// length codes, and the frame length. Attribute registers accept writes only
// while the section is not enabled. Assumes NUM_CH <= 16 and that each
// channel register block spans 16 addresses.
module tdm_demux_regs
    import tdm_demux_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int SLOT_W = 8,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic                           active,
    output logic                           alt_mode,
    output logic [1:0]                     rate,
    output logic                           clr,
    output logic [NUM_CH-1:0]              valid,
    output logic [NUM_CH-1:0][SLOT_W-1:0]  start,
    output logic [NUM_CH-1:0][1:0]         lcode,
    output logic [SLOT_W-1:0]              flen_m1,
    output logic [DATA_W-1:0]              ctrl_word
);

    logic en_q, rst_q, alt_q;
    logic [1:0] rate_q;
    logic wr_ctrl, attr_ok;
    logic unused_wdata;

    assign wr_ctrl      = wr_en && (addr == ADDR_W'(ADDR_CTRL));
    assign attr_ok      = wr_en && !en_q;
    assign clr          = wr_ctrl && wdata[CTRL_RST_BIT];
    assign unused_wdata = ^wdata;

    // Control register: reset overrides enable, mode and rate always writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            rst_q  <= 1'b0;
            alt_q  <= 1'b0;
            rate_q <= 2'd0;
        end else if (wr_ctrl) begin
            rst_q  <= wdata[CTRL_RST_BIT];
            en_q   <= wdata[CTRL_EN_BIT] && !wdata[CTRL_RST_BIT];
            alt_q  <= wdata[CTRL_ALT_BIT];
            rate_q <= wdata[1:0];
        end
    end

    // Valid vector and frame length, writable only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= '0;
            flen_m1 <= '0;
        end else if (attr_ok) begin
            if (addr == ADDR_W'(ADDR_VALID)) valid   <= wdata[NUM_CH-1:0];
            if (addr == ADDR_W'(ADDR_FLEN))  flen_m1 <= wdata[SLOT_W-1:0];
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        // Per-channel start slot and length code, writable only while stopped.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start[n] <= '0;
                lcode[n] <= '0;
            end else if (attr_ok) begin
                if (addr == ADDR_W'(ADDR_START_BASE + n)) start[n] <= wdata[SLOT_W-1:0];
                if (addr == ADDR_W'(ADDR_LEN_BASE + n))   lcode[n] <= wdata[1:0];
            end
        end
    end

    // Read-back image of the control register.
    always_comb begin
        ctrl_word               = '0;
        ctrl_word[CTRL_ALT_BIT] = alt_q;
        ctrl_word[CTRL_RST_BIT] = rst_q;
        ctrl_word[CTRL_EN_BIT]  = en_q;
        ctrl_word[1:0]          = rate_q;
    end

    assign active   = en_q;
    assign alt_mode = alt_q;
    assign rate     = rate_q;

    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> ($stable(valid) && $stable(flen_m1))); // R7

    AST_RESET_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADDR_CTRL) && wdata[CTRL_RST_BIT]) |=> !en_q); // R1

endmodule

// File: rtl/tdm_demux_frame.sv
// Frame timing for the demultiplexer: tracks the slot counter from each sync,
// decides which strobes carry a valid sample, detects truncated frames and
// divides completed frames down to the buffer-full rate.
// Assumes the frame length is at least one slot and at most 2**SLOT_W.
module tdm_demux_frame #(
    parameter int SLOT_W = 8,
    parameter int FCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              active_i,
    input  logic              bit_en_i,
    input  logic              fsync_i,
    input  logic [SLOT_W-1:0] flen_m1_i,
    input  logic [1:0]        rate_i,
    output logic              sample_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              tick_o,
    output logic              buf_irq_o,
    output logic              ferr_irq_o
);

    logic [SLOT_W-1:0] cnt_q;
    logic              in_frame_q;
    logic [FCNT_W-1:0] fcnt_q, fcnt_lim;
    logic              last;

    assign sample_o = active_i && bit_en_i && (fsync_i || in_frame_q);
    assign slot_o   = fsync_i ? '0 : cnt_q + 1'b1;
    assign last     = sample_o && (slot_o == flen_m1_i);
    assign fcnt_lim = FCNT_W'((32'd2 << rate_i) - 32'd1);
    assign tick_o   = last && (fcnt_q == fcnt_lim);

    // Slot counter and in-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q      <= '0;
            in_frame_q <= 1'b0;
        end else if (sample_o) begin
            cnt_q      <= slot_o;
            in_frame_q <= !last;
        end
    end

    // Completed-frame counter for the buffer-full rate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) fcnt_q <= '0;
        else if (last)       fcnt_q <= tick_o ? '0 : fcnt_q + 1'b1;
    end

    // Registered interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            buf_irq_o  <= 1'b0;
            ferr_irq_o <= 1'b0;
        end else begin
            buf_irq_o  <= tick_o;
            ferr_irq_o <= active_i && bit_en_i && fsync_i && in_frame_q;
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_irq_o |=> !buf_irq_o); // R5

    AST_FERR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_irq_o |-> $past(active_i)); // R8

endmodule

// File: rtl/tdm_demux_chan.sv
// One logical channel: shifts in the bits of its slot window MSB-first toward
// the LSB, counts accumulated bits, and loads the data register either on a
// full word (normal mode) or on every rate tick (transfer-all mode).
module tdm_demux_chan
    import tdm_demux_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              sample_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              din_i,
    input  logic              enable_i,
    input  logic [SLOT_W-1:0] start_i,
    input  logic [1:0]        lcode_i,
    input  logic              alt_i,
    input  logic              tick_i,
    output logic [WORD_W-1:0] data_o
);

    localparam int BCNT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] sh_q, sh_next;
    logic [BCNT_W-1:0] bits_q;
    logic [SLOT_W:0]   win_lo, win_hi, slot_x;
    logic              hit, full;

    assign slot_x  = {1'b0, slot_i};
    assign win_lo  = {1'b0, start_i};
    assign win_hi  = win_lo + (SLOT_W + 1)'(code_len(lcode_i));
    assign hit     = enable_i && sample_i && (slot_x >= win_lo) && (slot_x < win_hi);
    assign sh_next = hit ? {din_i, sh_q[WORD_W-1:1]} : sh_q;
    assign full    = hit && (bits_q == BCNT_W'(WORD_W - 1));

    // Shift register and accumulated-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sh_q   <= '0;
            bits_q <= '0;
        end else if (hit) begin
            sh_q   <= sh_next;
            bits_q <= bits_q + 1'b1;
        end
    end

    // Parallel data register load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)        data_o <= '0;
        else if (alt_i && tick_i)   data_o <= sh_next;
        else if (!alt_i && full)    data_o <= sh_next;
    end

    AST_BITS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (bits_q == $past(bits_q) || bits_q == $past(bits_q) + 1'b1)); // R4

endmodule

// File: rtl/tdm_demux_cfgchk.sv
// Configuration checker: flags a valid vector with gaps and enabled channels
// whose slot windows overlap or run backwards. Purely combinational.
module tdm_demux_cfgchk
    import tdm_demux_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int SLOT_W = 8
) (
    input  logic [NUM_CH-1:0]             valid_i,
    input  logic [NUM_CH-1:0][SLOT_W-1:0] start_i,
    input  logic [NUM_CH-1:0][1:0]        lcode_i,
    output logic                          err_o
);

    logic [NUM_CH-1:0] order_bad;
    logic              pack_bad;

    // A packed vector plus one is a power of two (or wraps to zero).
    assign pack_bad     = |(valid_i & (valid_i + 1'b1));
    assign order_bad[0] = 1'b0;

    for (genvar n = 1; n < NUM_CH; n++) begin : g_ord
        logic [SLOT_W:0] prev_end;
        assign prev_end     = {1'b0, start_i[n-1]} + (SLOT_W + 1)'(code_len(lcode_i[n-1]));
        assign order_bad[n] = valid_i[n] && ({1'b0, start_i[n]} < prev_end);
    end

    assign err_o = pack_bad || (|order_bad);

endmodule

// File: rtl/tdm_demux.sv
// Top level of the TDM serial input demultiplexer. Connects the register
// file, the frame timer, one channel slice per logical channel and the
// configuration checker, and provides the combinational register read mux.
// Assumes NUM_CH == 2**(ADDR_W-2) so each register group spans one quarter
// of the address space.
module tdm_demux
    import tdm_demux_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int WORD_W = 16,
    parameter int SLOT_W = 8,
    parameter int ADDR_W = 6,
    parameter int FCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ser_din,
    input  logic              fsync,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              buf_irq,
    output logic              ferr_irq,
    output logic              cfg_err
);

    localparam int CH_IDX_W = $clog2(NUM_CH);

    logic                          active, alt_mode, clr, sample, tick;
    logic [1:0]                    rate;
    logic [NUM_CH-1:0]             valid;
    logic [NUM_CH-1:0][SLOT_W-1:0] start;
    logic [NUM_CH-1:0][1:0]        lcode;
    logic [SLOT_W-1:0]             flen_m1, slot;
    logic [WORD_W-1:0]             ctrl_word;
    logic [NUM_CH-1:0][WORD_W-1:0] data;
    logic [CH_IDX_W-1:0]           idx;

    tdm_demux_regs #(
        .NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(WORD_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .active(active), .alt_mode(alt_mode), .rate(rate), .clr(clr),
        .valid(valid), .start(start), .lcode(lcode), .flen_m1(flen_m1),
        .ctrl_word(ctrl_word)
    );

    tdm_demux_frame #(.SLOT_W(SLOT_W), .FCNT_W(FCNT_W)) frame_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .active_i(active),
        .bit_en_i(bit_en), .fsync_i(fsync), .flen_m1_i(flen_m1), .rate_i(rate),
        .sample_o(sample), .slot_o(slot), .tick_o(tick),
        .buf_irq_o(buf_irq), .ferr_irq_o(ferr_irq)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        tdm_demux_chan #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) chan_i (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .sample_i(sample), .slot_i(slot),
            .din_i(ser_din), .enable_i(valid[n]), .start_i(start[n]),
            .lcode_i(lcode[n]), .alt_i(alt_mode), .tick_i(tick), .data_o(data[n])
        );
    end

    tdm_demux_cfgchk #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) cfgchk_i (
        .valid_i(valid), .start_i(start), .lcode_i(lcode), .err_o(cfg_err)
    );

    assign idx = reg_addr[CH_IDX_W-1:0];

    // Register read mux: data, start slots, length codes, then control group.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr[ADDR_W-1:ADDR_W-2])
            2'b00: reg_rdata = data[idx];
            2'b01: reg_rdata[SLOT_W-1:0] = start[idx];
            2'b10: reg_rdata[1:0] = lcode[idx];
            default: begin
                if (reg_addr == ADDR_W'(ADDR_CTRL))       reg_rdata = ctrl_word;
                else if (reg_addr == ADDR_W'(ADDR_VALID)) reg_rdata[NUM_CH-1:0] = valid;
                else if (reg_addr == ADDR_W'(ADDR_FLEN))  reg_rdata[SLOT_W-1:0] = flen_m1;
            end
        endcase
    end

    AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !clr) |=> $stable(data)); // R1

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_mode && !valid[NUM_CH-1] && !clr) |=> $stable(data[NUM_CH-1])); // R2

endmodule

// File: tb/tdm_demux_tb_top.sv
`timescale 1ns/1ps
module tdm_demux_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0, ser_din = 1'b0, fsync = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        buf_irq, ferr_irq, cfg_err;

    int n_checks = 0, n_err = 0;
    int irq_cnt = 0, ferr_cnt = 0;

    always #10 clk = ~clk;

    tdm_demux dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_din(ser_din), .fsync(fsync),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .buf_irq(buf_irq), .ferr_irq(ferr_irq), .cfg_err(cfg_err)
    );

    // Interrupt pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (buf_irq)  irq_cnt++;
        if (ferr_irq) ferr_cnt++;
    end

    function automatic logic bitval(int f, int s);
        int v = f * 37 + s * 11 + (f ^ s) * 5;
        return v[2];
    endfunction

    // Normal-mode word: 16 bits from frames f0.., earliest bit at bit 0.
    function automatic logic [15:0] exp_word(int st, int len, int f0);
        logic [15:0] w = '0;
        int k = 0;
        for (int f = f0; f < f0 + 16 / len; f++)
            for (int j = 0; j < len; j++) begin
                w[k] = bitval(f, st + j);
                k++;
            end
        return w;
    endfunction

    // Transfer-all word after two frames from a cleared shift register.
    function automatic logic [15:0] exp_alt(int st, int len);
        logic [15:0] w = '0;
        int k = 0;
        for (int f = 0; f < 2; f++)
            for (int j = 0; j < len; j++) begin
                w[16 - 2 * len + k] = bitval(f, st + j);
                k++;
            end
        return w;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = 6'(a);
        #1 v = reg_rdata;
    endtask

    task automatic send_frame(int f, int nslots);
        for (int s = 0; s < nslots; s++) begin
            @(negedge clk);
            bit_en = 1'b1; fsync = (s == 0); ser_din = bitval(f, s);
        end
        @(negedge clk);
        bit_en = 1'b0; fsync = 1'b0;
    endtask

    task automatic config_a();
        wr(49, 16'h000F);
        wr(16, 0);  wr(32, 3);
        wr(17, 8);  wr(33, 2);
        wr(18, 12); wr(34, 1);
        wr(19, 14); wr(35, 0);
        wr(50, 31);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(48, v); chk("R1 ctrl after reset", v, 0);
        rd(0, v);  chk("R4 data0 after reset", v, 0);
        chk("R5 buf_irq after reset", buf_irq, 0);
        chk("R8 ferr_irq after reset", ferr_irq, 0);
        chk("R9 cfg_err empty vector", cfg_err, 0);

        // Config A while stopped; traffic must not load anything (R1)
        config_a();
        rd(49, v); chk("R2 valid readback", v, 16'h000F);
        send_frame(0, 32); send_frame(1, 32);
        rd(0, v); chk("R1 stopped section ignores input", v, 0);

        // Start and run 16 frames in normal mode, rate 0
        irq_cnt = 0; ferr_cnt = 0;
        wr(48, 16'h0004);
        send_frame(0, 32); send_frame(1, 32);
        rd(0, v); chk("R3 ch0 8-bit word after 2 frames", v, exp_word(0, 8, 0));
        rd(1, v); chk("R4 ch1 not yet full", v, 0);
        for (int f = 2; f < 16; f++) send_frame(f, 32);
        @(negedge clk);
        rd(0, v); chk("R3 ch0 len8", v, exp_word(0, 8, 14));
        rd(1, v); chk("R3 ch1 len4", v, exp_word(8, 4, 12));
        rd(2, v); chk("R4 ch2 len2", v, exp_word(12, 2, 8));
        rd(3, v); chk("R4 ch3 len1", v, exp_word(14, 1, 0));
        rd(4, v); chk("R2 disabled ch4", v, 0);
        chk("R5 irq count rate0 16 frames", irq_cnt, 8);
        chk("R8 no error on full frames", ferr_cnt, 0);

        // Attribute writes ignored while running
        wr(49, 16'h0001); wr(16, 16'h0033); wr(32, 0); wr(50, 7);
        rd(49, v); chk("R7 valid unchanged", v, 16'h000F);
        rd(16, v); chk("R7 start0 unchanged", v, 0);
        rd(32, v); chk("R7 lcode0 unchanged", v, 3);
        rd(50, v); chk("R7 flen unchanged", v, 31);

        // Truncated frame
        ferr_cnt = 0;
        send_frame(16, 10); send_frame(17, 32);
        @(negedge clk);
        chk("R8 early sync flagged once", ferr_cnt, 1);

        // Section reset clears data
        wr(48, 16'h0010);
        rd(0, v); chk("R1 reset clears data0", v, 0);
        rd(48, v); chk("R1 ctrl shows reset", v, 16'h0010);

        // Configuration error checks
        wr(49, 16'h08FF); #1 chk("R9 gap in vector", cfg_err, 1);
        wr(49, 16'h000F); #1 chk("R9 packed vector ok", cfg_err, 0);
        wr(17, 5);        #1 chk("R10 overlap ch1", cfg_err, 1);
        wr(17, 8);        #1 chk("R10 exact boundary ok", cfg_err, 0);
        wr(18, 11);       #1 chk("R10 overlap ch2 by one", cfg_err, 1);
        wr(18, 12);       #1 chk("R10 restored", cfg_err, 0);

        // Transfer-all mode, then back to normal without reset
        irq_cnt = 0;
        wr(48, 16'h0204);
        send_frame(0, 32); send_frame(1, 32);
        @(negedge clk);
        chk("R6 one irq per 2 frames", irq_cnt, 1);
        rd(0, v); chk("R6 ch0 alt copy", v, exp_alt(0, 8));
        rd(1, v); chk("R6 ch1 alt partial", v, exp_alt(8, 4));
        rd(3, v); chk("R6 ch3 alt left aligned", v, exp_alt(14, 1));
        rd(5, v); chk("R6 ch5 idle copy", v, 0);
        wr(48, 16'h0004);
        send_frame(2, 32); send_frame(3, 32);
        rd(0, v); chk("R6 ch0 normal after mode change", v, exp_word(0, 8, 2));
        rd(1, v); chk("R6 ch1 continues accumulation", v, exp_word(8, 4, 0));

        // Sweep: every length code, three offsets, rate paired with length
        for (int c = 0; c < 4; c++) begin
            for (int si = 0; si < 3; si++) begin
                int st, len, nfr, rt;
                st  = (si == 0) ? 0 : ((si == 1) ? 5 : 17);
                len = 1 << c;
                nfr = 16 / len;
                rt  = 3 - c;
                wr(48, 16'h0010);
                wr(49, 1); wr(16, st); wr(32, c); wr(50, 31);
                irq_cnt = 0;
                wr(48, 16'h0004 | rt);
                for (int f = 0; f < nfr; f++) send_frame(f, 32);
                @(negedge clk);
                rd(0, v); chk($sformatf("R3 sweep code%0d start%0d", c, st), v, exp_word(st, len, 0));
                chk($sformatf("R5 sweep rate%0d irq count", rt), irq_cnt, 1);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule